// File: doc/BRIEF.md
# Microprogrammed Sequencer with Subroutines and Block Repeat

This block is the programmable controller for a time-shared datapath. On every clock it takes one 32-bit microword from an internal 256-entry control store and sends that word's 16-bit control field to the datapath. The address of the following microword comes from a program counter. By default the counter steps by one. A microword can also redirect it with an unconditional jump, with a jump that tests one of sixteen condition lines, with a subroutine call or return that uses a four-entry return stack, or with a hardware block-repeat that loops over a range of words without spending any cycles on loop bookkeeping.

While `run` is low the sequencer is parked at address 0 and its control outputs are zero. In this state the store accepts writes through a simple address/data/enable port. When `run` goes high, execution starts from address 0. If a call overflows the stack or a return finds it empty, a sticky error flag is set. That flag stays set until reset.

Top module: `useq_core`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) sets `pc_out` to 0, `ctrl_out` to 0 and `err_out` to 0. It also empties the return stack and clears the repeat unit. The contents of the control store are kept.
- R2: While `run` is low, every edge sets `pc_out` to 0 and `ctrl_out` to 0, empties the stack and clears the repeat unit. A write (`wr_en`) updates the store only while `run` is low. A write made while `run` is high has no effect.
- R3: Microword layout: opcode in bits [31:28], condition select in [27:24], target/count in [23:16], control field in [15:0]. After each edge with `run` high, `ctrl_out` holds the control field of the word that `pc_out` addressed before that edge. Opcode 0 (step), and any opcode from 6 to 15, moves the PC to PC+1 modulo 256.
- R4: Opcode 1 (jump) loads the PC with bits [23:16].
- R5: Opcode 2 (conditional jump) loads the PC with bits [23:16] when `cond[bits 27:24]` is high. Otherwise the PC goes to PC+1.
- R6: Opcode 3 (call) pushes PC+1 onto the return stack and loads the PC with bits [23:16]. Calls can nest up to 4 deep.
- R7: Opcode 4 (return) pops the most recent return address into the PC.
- R8: A call with 4 entries already on the stack, or a return with the stack empty, sets `err_out` and leaves the stack unchanged, and the PC goes to PC+1. `err_out` stays at 1 until reset.
- R9: Opcode 5 (repeat) loads a loop count from bits [27:24] and an end address from bits [23:16]. The block starts at the repeat word's address + 1, and the PC goes to PC+1. When the PC equals the end address and the count is nonzero, the next PC is the block start and the count drops by one in the same cycle, so the block runs count+1 times. This loop-back takes priority over the opcode of the end word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High: execute microcode; low: park at 0 and allow loading |
| wr_en | input | 1 | Control-store write enable (acts only while run is low) |
| wr_addr | input | 8 | Control-store write address |
| wr_data | input | 32 | Microword to write |
| cond | input | 16 | Condition lines tested by conditional jumps |
| ctrl_out | output | 16 | Registered control field for the datapath |
| pc_out | output | 8 | Address of the microword being fetched |
| err_out | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Every result appears one edge after its cause. The edge that consumes the word at `pc_out` shows that word's control field on `ctrl_out` and, at the same edge, the chosen next address on `pc_out`, with any error on `err_out`. A write or a change of `run` also takes effect at the next edge. The bench's behavioural model advances by one step per clock, using the same inputs the design sees at that edge. All three outputs are compared on the following falling edge. The programs exercise nested calls, block repeats (one of them on a single-word block that ends in a return), stack overflow and underflow, PC wrap, and a write attempted while running.

// File: rtl/useq_pkg.sv
// Package: shared widths, opcode encoding and microword layout for the
// microprogrammed sequencer. Assumes a 32-bit word with fixed field positions.
package useq_pkg;
    localparam int ADDR_W  = 8;                 // control-store address width
    localparam int CTRL_W  = 16;                // control field width
    localparam int SEL_W   = 4;                 // condition select / repeat count width
    localparam int OP_W    = 4;                 // opcode width
    localparam int WORD_W  = OP_W + SEL_W + ADDR_W + CTRL_W;
    localparam int N_COND  = 1 << SEL_W;        // number of condition lines
    localparam int N_WORDS = 1 << ADDR_W;       // control-store depth

    typedef enum logic [OP_W-1:0] {
        OP_STEP   = 4'd0,
        OP_JUMP   = 4'd1,
        OP_JCOND  = 4'd2,
        OP_CALL   = 4'd3,
        OP_RET    = 4'd4,
        OP_REPEAT = 4'd5
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] arg;
        logic [CTRL_W-1:0] ctrl;
    } uword_t;
endpackage

// File: rtl/useq_store.sv
// Control store: DEPTH words of WIDTH bits. One synchronous write port and
// one combinational read port. Assumes the caller gates writes (no reset of
// the contents).
module useq_store #(
    parameter int WIDTH = 32,
    parameter int AW    = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Write one word when enabled
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Combinational fetch of the addressed word
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/useq_rstack.sv
// Return-address stack (LIFO) of DEPTH entries. A push when full or a pop
// when empty is refused here; the caller is told via full/empty and must
// flag the error. Assumes push and pop are never asserted together.
module useq_rstack #(
    parameter int AW    = 8,
    parameter int DEPTH = 4,
    localparam int SPW  = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0]  ent_q [DEPTH];
    logic [SPW-1:0] sp_q;
    logic [IW-1:0]  wr_idx;
    logic [IW-1:0]  top_idx;

    assign full    = (sp_q == SPW'(DEPTH));
    assign empty   = (sp_q == '0);
    assign wr_idx  = IW'(sp_q);
    assign top_idx = IW'(sp_q - SPW'(1));
    assign top_data = ent_q[top_idx];

    // Track stack depth; refused pushes/pops leave it unchanged
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          sp_q <= '0;
        else if (push && !full)     sp_q <= sp_q + SPW'(1);
        else if (pop && !empty)     sp_q <= sp_q - SPW'(1);
    end

    // Store the pushed return address in the slot above the top
    always_ff @(posedge clk) begin
        if (push && !full && !clr) ent_q[wr_idx] <= push_data;
    end

    // R8
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> (sp_q == $past(sp_q)));
    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !clr) |=> (sp_q == '0));
    // R6
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !clr) |=> (sp_q == $past(sp_q) + SPW'(1)));
endmodule

// File: rtl/useq_loop.sv
// Block-repeat unit: holds a remaining-pass count, the block start and the
// block end. It raises hit when the fetch address equals the end and passes
// remain. Assumes the caller gives hit priority over a new load.
module useq_loop #(
    parameter int AW  = 8,
    parameter int CNW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [AW-1:0]  pc,
    input  logic           load,
    input  logic [CNW-1:0] load_cnt,
    input  logic [AW-1:0]  load_end,
    input  logic [AW-1:0]  load_start,
    output logic           hit,
    output logic [AW-1:0]  start_addr
);
    logic [CNW-1:0] cnt_q;
    logic [AW-1:0]  end_q;
    logic [AW-1:0]  start_q;

    assign hit        = (cnt_q != '0) && (pc == end_q);
    assign start_addr = start_q;

    // Load a new loop, or count one pass at each loop-back
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q   <= '0;
            end_q   <= '0;
            start_q <= '0;
        end else if (step && hit) begin
            cnt_q <= cnt_q - CNW'(1);
        end else if (step && load) begin
            cnt_q   <= load_cnt;
            end_q   <= load_end;
            start_q <= load_start;
        end
    end

    // R9
    loop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hit && !clr) |=> (cnt_q == $past(cnt_q) - CNW'(1)));
    // R9
    loop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit && !load && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/useq_core.sv
// Microprogrammed sequencer top. It fetches one microword per cycle from the
// control store, registers its control field and forms the next address
// (step, jump, conditional jump, call/return, block repeat). Assumes the
// store is loaded while run is low; execution starts at address 0.
module useq_core
    import useq_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [N_COND-1:0]   cond,
    output logic [CTRL_W-1:0]   ctrl_out,
    output logic [ADDR_W-1:0]   pc_out,
    output logic                err_out
);
    logic [ADDR_W-1:0] pc_q, pc_nxt, pc_inc;
    logic [CTRL_W-1:0] ctrl_q;
    logic              err_q, err_set;
    logic [WORD_W-1:0] rd_word;
    uword_t            uw;
    logic              st_push, st_pop, st_full, st_empty;
    logic [ADDR_W-1:0] st_top;
    logic              lp_load, lp_hit;
    logic [ADDR_W-1:0] lp_start;

    useq_store #(.WIDTH(WORD_W), .AW(ADDR_W)) u_store (
        .clk(clk), .we(wr_en && !run), .waddr(wr_addr), .wdata(wr_data),
        .raddr(pc_q), .rdata(rd_word)
    );

    assign uw     = uword_t'(rd_word);
    assign pc_inc = pc_q + ADDR_W'(1);

    useq_rstack #(.AW(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(!run),
        .push(st_push), .pop(st_pop), .push_data(pc_inc),
        .top_data(st_top), .full(st_full), .empty(st_empty)
    );

    useq_loop #(.AW(ADDR_W), .CNW(SEL_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(run), .pc(pc_q),
        .load(lp_load), .load_cnt(uw.sel), .load_end(uw.arg),
        .load_start(pc_inc), .hit(lp_hit), .start_addr(lp_start)
    );

    // Next-address selection; loop-back wins over the word's own opcode
    always_comb begin
        pc_nxt  = pc_inc;
        st_push = 1'b0;
        st_pop  = 1'b0;
        lp_load = 1'b0;
        err_set = 1'b0;
        if (lp_hit) begin
            pc_nxt = lp_start;
        end else begin
            case (uw.op)
                OP_JUMP:   pc_nxt = uw.arg;
                OP_JCOND:  if (cond[uw.sel]) pc_nxt = uw.arg;
                OP_CALL: begin
                    if (st_full) err_set = 1'b1;
                    else begin
                        st_push = run;
                        pc_nxt  = uw.arg;
                    end
                end
                OP_RET: begin
                    if (st_empty) err_set = 1'b1;
                    else begin
                        st_pop = run;
                        pc_nxt = st_top;
                    end
                end
                OP_REPEAT: lp_load = 1'b1;
                default:   pc_nxt = pc_inc;
            endcase
        end
    end

    // Program counter: parked at 0 in reset or while not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pc_q <= '0;
        else                pc_q <= pc_nxt;
    end

    // Registered control field of the word just consumed
    always_ff @(posedge clk) begin
        if (!rst_n || !run) ctrl_q <= '0;
        else                ctrl_q <= uw.ctrl;
    end

    // Sticky stack error flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)              err_q <= 1'b0;
        else if (run && err_set) err_q <= 1'b1;
    end

    assign ctrl_out = ctrl_q;
    assign pc_out   = pc_q;
    assign err_out  = err_q;

    // R2
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pc_q == '0 && ctrl_q == '0));
    // R3
    ctrl_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (ctrl_q == $past(uw.ctrl)));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R6
    call_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_push) |=> (pc_q == $past(uw.arg)));
endmodule

// File: tb/useq_core_test.sv
// Bench: behavioural reference model (array, queue, integers) stepped once per
// clock and compared with the design on every falling edge.
module useq_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] cond = '0;
    logic [15:0] ctrl_out;
    logic [7:0]  pc_out;
    logic        err_out;

    useq_core uut (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cond(cond),
        .ctrl_out(ctrl_out), .pc_out(pc_out), .err_out(err_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    logic [31:0] m [256];
    int          mpc = 0;
    int          stk[$];
    int          lcnt = 0, lend = 0, lstart = 0;
    bit          merr = 0;
    logic [15:0] mctrl = '0;
    string       tag = "R1";
    int          checks = 0, fails = 0, cyc = 0;
    bit          done = 0;

    function automatic logic [31:0] mk(int op, int sel, int arg, int ctl);
        return {4'(op), 4'(sel), 8'(arg), 16'(ctl)};
    endfunction

    task automatic model_step();
        logic [31:0] w;
        int op, sel, arg, npc;
        if (!rst_n) begin
            mpc = 0; stk.delete(); lcnt = 0; lend = 0; lstart = 0;
            merr = 0; mctrl = '0; tag = "R1";
        end else if (!run) begin
            mpc = 0; stk.delete(); lcnt = 0; lend = 0; lstart = 0;
            mctrl = '0; tag = "R2";
        end else begin
            w = m[mpc];
            mctrl = w[15:0];
            op = int'(w[31:28]); sel = int'(w[27:24]); arg = int'(w[23:16]);
            npc = (mpc + 1) % 256;
            tag = "R3";
            if (lcnt != 0 && mpc == lend) begin
                npc = lstart; lcnt--; tag = "R9";
            end else begin
                case (op)
                    1: begin npc = arg; tag = "R4"; end
                    2: begin if (cond[sel]) npc = arg; tag = "R5"; end
                    3: if (stk.size() < 4) begin
                           stk.push_back((mpc + 1) % 256); npc = arg; tag = "R6";
                       end else begin merr = 1; tag = "R8"; end
                    4: if (stk.size() > 0) begin
                           npc = stk.pop_back(); tag = "R7";
                       end else begin merr = 1; tag = "R8"; end
                    5: begin lcnt = sel; lend = arg; lstart = (mpc + 1) % 256; tag = "R9"; end
                    default: tag = "R3";
                endcase
            end
            mpc = npc;
        end
        if (wr_en && !run) m[wr_addr] = wr_data;
    endtask

    task automatic cycle_once();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        checks++;
        if (pc_out !== 8'(mpc) || ctrl_out !== mctrl || err_out !== merr) begin
            fails++;
            $display("FAIL %s cyc %0d: pc %0d exp %0d, ctrl %h exp %h, err %0d exp %0d",
                     tag, cyc, pc_out, mpc, ctrl_out, mctrl, err_out, merr);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
        cycle_once();
        wr_en = 1'b0;
    endtask

    task automatic run_for(int n);
        for (int i = 0; i < n; i++) begin
            cond = '0;
            cond[3] = (cyc % 7 == 0);
            cond[0] = (cyc % 3 != 0);
            cycle_once();
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        repeat (3) cycle_once();
        rst_n = 1'b1;
        // fill whole store with step words (R3 default behaviour)
        for (int a = 0; a < 256; a++) wr(a, mk(0, 0, 0, 16'hA500 | a));
        // program A: jumps, conditional jump, nested calls, repeats
        wr(0,  mk(0, 0, 0,  16'h1000));
        wr(1,  mk(1, 0, 5,  16'h1001));
        wr(5,  mk(2, 3, 8,  16'h1005));
        wr(6,  mk(1, 0, 1,  16'h1006));
        wr(8,  mk(3, 0, 20, 16'h1008));
        wr(9,  mk(5, 2, 11, 16'h1009));
        wr(12, mk(3, 0, 30, 16'h100C));
        wr(13, mk(2, 0, 13, 16'h100D));
        wr(20, mk(3, 0, 25, 16'h1014));
        wr(21, mk(4, 0, 0,  16'h1015));
        wr(25, mk(3, 0, 28, 16'h1019));
        wr(26, mk(4, 0, 0,  16'h101A));
        wr(28, mk(5, 1, 29, 16'h101C));
        wr(29, mk(4, 0, 0,  16'h101D));
        wr(30, mk(4, 0, 0,  16'h101E));
        wr(40, mk(1, 0, 0,  16'h1028));
        run = 1'b1;
        run_for(160);
        // R2: stop mid-run, then program B (stack overflow and underflow)
        run = 1'b0;
        cycle_once();
        wr(0, mk(3, 0, 2,  16'h2000));
        wr(2, mk(3, 0, 4,  16'h2002));
        wr(4, mk(3, 0, 6,  16'h2004));
        wr(6, mk(3, 0, 8,  16'h2006));
        wr(8, mk(3, 0, 10, 16'h2008));
        for (int a = 1; a < 10; a += 2) wr(a, mk(4, 0, 0, 16'h2100 | a));
        wr(10, mk(1, 0, 0, 16'h200A));
        run = 1'b1;
        run_for(40);
        // R1: reset clears error; program C: underflow, repeat ending on a jump
        run = 1'b0;
        rst_n = 1'b0;
        cycle_once();
        rst_n = 1'b1;
        wr(0, mk(4, 0, 0,  16'h3000));
        wr(1, mk(5, 3, 3,  16'h3001));
        wr(2, mk(0, 0, 0,  16'h3002));
        wr(3, mk(1, 0, 0,  16'h3003));
        run = 1'b1;
        run_for(5);
        // R2: write while running must be ignored
        wr(2, mk(0, 0, 0, 16'hDEAD));
        run_for(20);
        // R3: PC wraps from 255 to 0
        run = 1'b0;
        rst_n = 1'b0;
        cycle_once();
        rst_n = 1'b1;
        wr(0, mk(1, 0, 253, 16'h4000));
        wr(255, mk(0, 0, 0, 16'h40FF));
        run = 1'b1;
        run_for(12);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d (R1 sequence incomplete)", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule